// File: doc/BRIEF.md
# ALU Status Flag Generator

This block evaluates two operands under an add, subtract or bitwise logic operation, at either byte or word width. From the result it derives six arithmetic status flags and keeps them in a flag register. The same register holds three control bits: direction, interrupt enable and trap. Only explicit set and clear strobes move those three bits. ALU activity never touches them.

The execution datapath presents the operands, an operation code and a width bit on each cycle. An update strobe decides whether the computed status is captured. Holding the strobe low lets an operation such as a loop counter decrement go by without disturbing the flags. All flags appear on one registered vector, one clock after the inputs that produce them.

Top module: `flag_unit`

## Requirements
- R1: With wide_i = 0 the operation is 8-bit: operand bits 15..8 have no effect on any flag, and carry, sign, zero and overflow are taken at bit 7. With wide_i = 1 the operation is 16-bit and these flags are taken at bit 15.
- R2: The carry flag (flags_o[0]) is set on a carry out of the selected width for add (op_i = 0). For subtract (op_i = 1, computing a_i - b_i) it is set when a borrow occurs, that is when a_i < b_i at the selected width.
- R3: The overflow flag (flags_o[5]) is set when the signed two's-complement result of add or subtract does not fit in the selected width.
- R4: The sign flag (flags_o[4]) equals the top bit of the result at the selected width. The zero flag (flags_o[3]) is 1 exactly when the result at the selected width is zero.
- R5: The parity flag (flags_o[1]) is 1 when the low 8 bits of the result hold an even number of ones, and 0 otherwise, at either width.
- R6: The auxiliary flag (flags_o[2]) is set on a carry out of bit 3 for add, or a borrow into bit 3 for subtract, in the low byte.
- R7: The logic operations AND (op_i = 2), OR (op_i = 3) and XOR (op_i = 4) clear carry and overflow, leave the auxiliary flag unchanged, and set sign, zero and parity from the result.
- R8: The control bits direction (flags_o[6]), interrupt enable (flags_o[7]) and trap (flags_o[8]) are driven by ctl_set_i[i] and ctl_clr_i[i], where i = 0, 1, 2 maps to bit 6 + i. Clear wins over set. With neither strobe the bit holds, whatever the ALU inputs.
- R9: When upd_i = 0, or op_i is 5, 6 or 7, all six status flags keep their value.
- R10: While rst_ni is low, every bit of flags_o is 0.
- R11: Flags change one clock after the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 16 | First operand (minuend for subtract) |
| b_i | input | 16 | Second operand |
| op_i | input | 3 | 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5-7 no flag change |
| wide_i | input | 1 | 0 = 8-bit, 1 = 16-bit operation |
| upd_i | input | 1 | Capture status flags this cycle |
| ctl_set_i | input | 3 | Set strobes for direction, interrupt enable, trap |
| ctl_clr_i | input | 3 | Clear strobes for the same bits, dominant |
| flags_o | output | 9 | {trap, ie, dir, of, sf, zf, af, pf, cf} |

## Verification
Directed cases come first. A byte add whose word operands differ in the high byte separates true 8-bit behaviour from word arithmetic that has been truncated. Other cases are a signed 0x7FFF + 1, a byte 0 - 1 borrow, and a nibble-boundary 0x0F + 0x01 that isolates the auxiliary carry. An XOR that yields 0x0100 shows that parity looks only at the low byte while zero sees the whole word. A logic operation that follows a set auxiliary flag confirms the hold. After these, thousands of random cycles mix all eight operation codes, both widths, the update strobe and overlapping set and clear strobes. A behavioural model checks every flag on every clock against them.

// File: rtl/flag_pkg.sv
package flag_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;

  // packed: cf is bit 0
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } stat_t;

  localparam int NSTAT = 6;
endpackage

// File: rtl/flag_arith.sv
module flag_arith
  import flag_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [2:0]    op_i,
  input  logic          wide_i,
  output logic [DW-1:0] res_o,
  output logic          cf_o,
  output logic          af_o,
  output logic          of_o,
  output logic          valid_o,
  output logic          logic_o
);
  localparam int HW = DW - NW;

  logic [DW-1:0] a_m, b_m;
  logic [DW:0]   sum, dif;
  logic [4:0]    lo_sum, lo_dif;
  logic [DW-1:0] raw;
  logic          sa, sb, sr;

  always_comb begin
    a_m    = wide_i ? a_i : {{HW{1'b0}}, a_i[NW-1:0]};
    b_m    = wide_i ? b_i : {{HW{1'b0}}, b_i[NW-1:0]};
    sum    = {1'b0, a_m} + {1'b0, b_m};
    dif    = {1'b0, a_m} - {1'b0, b_m};
    lo_sum = {1'b0, a_m[3:0]} + {1'b0, b_m[3:0]};
    lo_dif = {1'b0, a_m[3:0]} - {1'b0, b_m[3:0]};
    sa     = wide_i ? a_m[DW-1] : a_m[NW-1];
    sb     = wide_i ? b_m[DW-1] : b_m[NW-1];
    raw     = '0;
    cf_o    = 1'b0;
    af_o    = 1'b0;
    valid_o = 1'b1;
    logic_o = 1'b0;
    case (op_i)
      OP_ADD: begin
        raw  = sum[DW-1:0];
        cf_o = wide_i ? sum[DW] : sum[NW];
        af_o = lo_sum[4];
      end
      OP_SUB: begin
        raw  = dif[DW-1:0];
        cf_o = dif[DW];          // operands zero-extended: sign of wide diff is borrow
        af_o = lo_dif[4];
      end
      OP_AND: begin raw = a_m & b_m; logic_o = 1'b1; end
      OP_OR:  begin raw = a_m | b_m; logic_o = 1'b1; end
      OP_XOR: begin raw = a_m ^ b_m; logic_o = 1'b1; end
      default: valid_o = 1'b0;
    endcase
    res_o = wide_i ? raw : {{HW{1'b0}}, raw[NW-1:0]};
    sr    = wide_i ? res_o[DW-1] : res_o[NW-1];
    unique case (op_i)
      OP_ADD:  of_o = (sa == sb) && (sr != sa);
      OP_SUB:  of_o = (sa != sb) && (sr != sa);
      default: of_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/flag_eval.sv
module flag_eval #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic [DW-1:0] res_i,
  input  logic          wide_i,
  output logic          zf_o,
  output logic          sf_o,
  output logic          pf_o
);
  assign zf_o = (res_i == '0);
  assign sf_o = wide_i ? res_i[DW-1] : res_i[NW-1];
  assign pf_o = ~(^res_i[NW-1:0]);
endmodule

// File: rtl/flag_ctl_bit.sv
module flag_ctl_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NW   = 8,
  parameter int NCTL = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DW-1:0]         a_i,
  input  logic [DW-1:0]         b_i,
  input  logic [2:0]            op_i,
  input  logic                  wide_i,
  input  logic                  upd_i,
  input  logic [NCTL-1:0]       ctl_set_i,
  input  logic [NCTL-1:0]       ctl_clr_i,
  output logic [NSTAT+NCTL-1:0] flags_o
);
  logic [DW-1:0]   res;
  logic            cf, af, of_b, zf, sf, pf, valid, is_logic;
  stat_t           stat_q;
  logic [NCTL-1:0] ctl_q;

  flag_arith #(.DW(DW), .NW(NW)) u_arith (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .wide_i(wide_i),
    .res_o(res), .cf_o(cf), .af_o(af), .of_o(of_b),
    .valid_o(valid), .logic_o(is_logic)
  );

  flag_eval #(.DW(DW), .NW(NW)) u_eval (
    .res_i(res), .wide_i(wide_i), .zf_o(zf), .sf_o(sf), .pf_o(pf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (upd_i && valid) begin
      stat_q.cf <= cf;
      stat_q.of <= of_b;
      stat_q.af <= is_logic ? stat_q.af : af;
      stat_q.zf <= zf;
      stat_q.sf <= sf;
      stat_q.pf <= pf;
    end
  end

  for (genvar i = 0; i < NCTL; i++) begin : g_ctl
    flag_ctl_bit u_bit (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(ctl_set_i[i]), .clr_i(ctl_clr_i[i]), .q_o(ctl_q[i])
    );
  end

  assign flags_o = {ctl_q, stat_q};
endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk #(
  parameter int DW   = 16,
  parameter int NW   = 8,
  parameter int NCTL = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [DW-1:0]      a_i,
  input logic [DW-1:0]      b_i,
  input logic [2:0]         op_i,
  input logic               wide_i,
  input logic               upd_i,
  input logic [NCTL-1:0]    ctl_set_i,
  input logic [NCTL-1:0]    ctl_clr_i,
  input logic [6+NCTL-1:0]  flags_o
);
  logic is_logic_op;
  assign is_logic_op = (op_i == 3'd2) || (op_i == 3'd3) || (op_i == 3'd4);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i || op_i > 3'd4) |=> $stable(flags_o[5:0]));

  p_logic_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && is_logic_op) |=> (!flags_o[0] && !flags_o[5] && $stable(flags_o[2])));

  p_zero_not_neg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags_o[3] && flags_o[4]));

  p_byte_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wide_i && op_i <= 3'd4 && a_i[NW-1:0] == '0 && b_i[NW-1:0] == '0)
      |=> flags_o[3]);

  for (genvar i = 0; i < NCTL; i++) begin : g_ctl_chk
    p_ctl_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_set_i[i] && !ctl_clr_i[i]) |=> flags_o[6+i]);
    p_ctl_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl_clr_i[i] |=> !flags_o[6+i]);
    p_ctl_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctl_set_i[i] && !ctl_clr_i[i]) |=> $stable(flags_o[6+i]));
  end
endmodule

bind flag_unit flag_unit_chk #(.DW(DW), .NW(NW), .NCTL(NCTL)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .op_i(op_i),
  .wide_i(wide_i), .upd_i(upd_i), .ctl_set_i(ctl_set_i),
  .ctl_clr_i(ctl_clr_i), .flags_o(flags_o)
);

// File: tb/flag_unit_tb.sv
`timescale 1ns/1ps
module flag_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] a_i, b_i;
  logic [2:0]  op_i;
  logic        wide_i, upd_i;
  logic [2:0]  ctl_set_i, ctl_clr_i;
  logic [8:0]  flags_o;

  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  logic [8:0] exp_q;

  always #5 clk_i = ~clk_i;

  flag_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .wide_i(wide_i), .upd_i(upd_i), .ctl_set_i(ctl_set_i),
    .ctl_clr_i(ctl_clr_i), .flags_o(flags_o)
  );

  function automatic logic [8:0] ref_next(logic [8:0] prev, int a, int b, int op,
                                          bit wide, bit upd, logic [2:0] st, logic [2:0] cl);
    logic [8:0] n = prev;
    int mask = wide ? 65535 : 255;
    int top  = wide ? 15 : 7;
    int ua = a & mask, ub = b & mask, r = 0, ones = 0;
    bit c = 0, ax = 0, ov = 0, sa, sb, sr;
    sa = ((ua >> top) & 1) != 0;
    sb = ((ub >> top) & 1) != 0;
    if (upd && op <= 4) begin
      case (op)
        0: begin r = (ua + ub) & mask; c = (ua + ub) > mask; ax = ((ua % 16) + (ub % 16)) > 15; end
        1: begin r = (ua - ub + mask + 1) & mask; c = ua < ub; ax = (ua % 16) < (ub % 16); end
        2: r = ua & ub;
        3: r = ua | ub;
        default: r = ua ^ ub;
      endcase
      sr = ((r >> top) & 1) != 0;
      if (op == 0) ov = (sa == sb) && (sr != sa);
      if (op == 1) ov = (sa != sb) && (sr != sa);
      for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
      n[0] = c;
      n[1] = (ones % 2) == 0;
      if (op <= 1) n[2] = ax;
      n[3] = (r == 0);
      n[4] = sr;
      n[5] = ov;
    end
    for (int i = 0; i < 3; i++) begin
      if (cl[i]) n[6+i] = 1'b0;
      else if (st[i]) n[6+i] = 1'b1;
    end
    return n;
  endfunction

  function automatic string bit_req(int k);
    case (k)
      0: return "R2 cf";
      1: return "R5 pf";
      2: return "R6 af";
      3: return "R4 zf";
      4: return "R4 sf";
      5: return "R3 of";
      default: return "R8 ctl";
    endcase
  endfunction

  task automatic compare(string scen);
    n_run++;
    if (flags_o !== exp_q) begin
      n_fail++;
      for (int k = 0; k < 9; k++)
        if (flags_o[k] !== exp_q[k])
          $display("FAIL %s [%s] bit %0d: got %b exp %b (vector got %h exp %h)",
                   scen, bit_req(k), k, flags_o[k], exp_q[k], flags_o, exp_q);
    end
  endtask

  // drive at negedge, flags register at next posedge (R11), compare at following negedge
  task automatic step(string scen, int a, int b, int op, bit wide, bit upd,
                      logic [2:0] st, logic [2:0] cl);
    a_i = a[15:0]; b_i = b[15:0]; op_i = op[2:0];
    wide_i = wide; upd_i = upd; ctl_set_i = st; ctl_clr_i = cl;
    exp_q = ref_next(exp_q, a, b, op, wide, upd, st, cl);
    @(negedge clk_i);
    compare(scen);
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R11: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; a_i = '0; b_i = '0; op_i = '0; wide_i = 0; upd_i = 0;
    ctl_set_i = '0; ctl_clr_i = '0; exp_q = '0;
    ctl_set_i = 3'b111; upd_i = 1; a_i = 16'h0080; b_i = 16'h0080;
    repeat (3) @(negedge clk_i);
    compare("R10 reset");
    ctl_set_i = '0; upd_i = 0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R10 after release");

    step("R1 byte add high bytes ignored", 'h12FF, 'h3401, 0, 0, 1, 0, 0);
    step("R1 same byte pair wide",          'h12FF, 'h3401, 0, 1, 1, 0, 0);
    step("R3 wide signed overflow",         'h7FFF, 'h0001, 0, 1, 1, 0, 0);
    step("R3 byte signed overflow sub",     'h0080, 'h0001, 1, 0, 1, 0, 0);
    step("R2 byte borrow",                  'h0000, 'h0001, 1, 0, 1, 0, 0);
    step("R6 nibble carry",                 'h000F, 'h0001, 0, 0, 1, 0, 0);
    step("R7 logic keeps af",               'hFFFF, 'h00F0, 2, 1, 1, 0, 0);
    step("R5 parity low byte only",         'h0100, 'h0000, 4, 1, 1, 0, 0);
    step("R9 update off",                   'h0000, 'h0000, 0, 1, 0, 0, 0);
    step("R9 reserved op",                  'h0001, 'h0002, 6, 0, 1, 0, 0);
    step("R8 set all",                      'h0000, 'h0000, 5, 0, 1, 3'b111, 0);
    step("R8 clear wins",                   'hFFFF, 'hFFFF, 0, 1, 1, 3'b101, 3'b001);
    step("R8 hold under alu",               'h8000, 'h8000, 0, 1, 1, 0, 0);
    step("R7 or byte",                      'hAB00, 'h0080, 3, 0, 1, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 3);
      int a = $urandom_range(0, 65535);
      int b = $urandom_range(0, 65535);
      if (sel == 0) b = a;
      if (sel == 1) begin a = a & 'hFF0F; b = b & 'hFF0F; end
      step("R1 random", a, b, $urandom_range(0, 7), 1'($urandom_range(0, 1)),
           $urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 3)));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule